// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer

This block is a 16-bit timer that counts on a prescaled clock and reloads itself when it reaches a bound. A time-out sets a sticky timer flag. A second flag toggles on each time-out, so it can be read as a seventeenth count bit. When up/down operation is enabled, a direction input picks the count direction. Otherwise the timer only counts up.

Two bound schemes are available. In the first, the count runs between the all-ones value and a floor held in the reload register. In the second, it runs between a ceiling held in a separate top register and a floor held in the reload register. In both schemes, reaching the bound in the current direction loads the opposite bound. Software can write the count, the reload register and the top register directly. A direct write to the count wins over counting in the same cycle.

Top module: `updown_reload_timer`

## Requirements
- R1: After reset the count, reload register, top register, timer flag and extension flag are all zero.
- R2: With `run` high, the count moves once every 2^`psel` clock cycles, where `psel` = 0 means every cycle. The prescaler restarts from zero whenever `run` is low, and while `run` is low the count holds.
- R3: When `updn_en` is 1, `dir` = 1 counts up and `dir` = 0 counts down. When `updn_en` is 0 the timer counts up whatever `dir` is.
- R4: With `bound_sel` = 0, an up-step taken while the count is 0xFFFF loads the reload value and sets `tf`.
- R5: With `bound_sel` = 0, a down-step taken while the count equals the reload value loads 0xFFFF and sets `tf`.
- R6: With `bound_sel` = 1, an up-step taken while the count equals the top register loads the reload value and sets `tf`.
- R7: With `bound_sel` = 1, a down-step taken while the count equals the reload value loads the top register and sets `tf`.
- R8: `ext` inverts on every time-out while `updn_en` is 1. It does not change while `updn_en` is 0.
- R9: `tf` stays set until a `tf_clr` pulse clears it. If a clear and a time-out fall in the same cycle, `tf` ends up set.
- R10: A `cnt_we` write loads `cnt_wdata` into the count in the next cycle, even in a cycle that would otherwise step or reload. Such a cycle records no time-out.
- R11: While the direction is constant, the time-out period is (top − reload + 1) steps in both directions. Reversing the direction while the count sits at a bound causes an immediate time-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Count enable |
| psel | input | 4 | Prescale exponent; the divide ratio is 2^psel |
| updn_en | input | 1 | Enables direction control by `dir` |
| dir | input | 1 | 1 = up, 0 = down (used when `updn_en` is 1) |
| bound_sel | input | 1 | 0 = all-ones/reload bounds, 1 = top/reload bounds |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 16 | Count write value |
| rld_we | input | 1 | Reload register write strobe |
| rld_wdata | input | 16 | Reload register write value |
| top_we | input | 1 | Top register write strobe |
| top_wdata | input | 16 | Top register write value |
| tf_clr | input | 1 | Clears the timer flag |
| count | output | 16 | Current count |
| rld_q | output | 16 | Reload register contents |
| top_q | output | 16 | Top register contents |
| tf | output | 1 | Sticky time-out flag |
| ext | output | 1 | Extension bit, inverted on each time-out |

## Verification
A wrong bound decode shows on `count` within one prescaled step of reaching the bound: the count either passes through the bound or loads the wrong value. A prescaler fault shifts the first visible count change by at least one cycle, so the check of the cycle-exact count sequence at `psel` = 2 exposes it. A corrupted `tf` or `ext` bit shows on the same clock edge as the time-out that should have set or toggled it. Write priority is checked by writing in a cycle that would otherwise wrap the count.

// File: rtl/utmr_pkg.sv
// Package: shared types for the up/down auto-reload timer.
// Assumes: nothing beyond IEEE 1800-2017.
package utmr_pkg;

    // Selects which pair of values bounds the count.
    typedef enum logic {
        BND_ONES_FLOOR = 1'b0,  // all-ones ceiling, reload register floor
        BND_TOP_FLOOR  = 1'b1   // top register ceiling, reload register floor
    } bound_e;

endpackage

// File: rtl/utmr_prescale.sv
// Module: utmr_prescale
// Produces a one-cycle count tick every 2^psel enabled cycles.
// Assumes: psel is held steady while run is high; the divider restarts
// from zero whenever run is low.
module utmr_prescale #(
    parameter int PS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] psel,
    output logic            tick
);

    localparam int DIV_W = (1 << PS_W) - 1;
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] mask;

    // One mask bit for each divider stage below the selected exponent.
    generate
        for (genvar gi = 0; gi < DIV_W; gi++) begin : g_mask
            assign mask[gi] = (int'(psel) > gi);
        end
    endgenerate

    // Free-running divider, cleared when the timer is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + ONE;
        end
    end

    // Tick when every selected divider bit is set.
    always_comb begin
        tick = run && ((pre_q & mask) == mask);
    end

    // Once the divide ratio is above one, two ticks never fall in adjacent cycles.
    p_tick_gap_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psel != '0) |=> (!tick || psel == '0));

endmodule

// File: rtl/utmr_bounds.sv
// Module: utmr_bounds
// Decides, for the current direction and bound scheme, whether the count
// sits at its limit and which value is loaded on a time-out.
// Assumes: purely combinational; the limit compare uses the live count.
module utmr_bounds
    import utmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  bound_e           bsel,
    input  logic             up,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] floor_v,
    input  logic [CNT_W-1:0] top_v,
    output logic             at_limit,
    output logic [CNT_W-1:0] load_v
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] ceil_v;

    // Ceiling is all ones or the top register, depending on the scheme.
    always_comb begin
        ceil_v = (bsel == BND_TOP_FLOOR) ? top_v : ALL_ONES;
    end

    // Up: stop at the ceiling, load the floor. Down: stop at the floor, load the ceiling.
    always_comb begin
        if (up) begin
            at_limit = (count == ceil_v);
            load_v   = floor_v;
        end else begin
            at_limit = (count == floor_v);
            load_v   = ceil_v;
        end
    end

endmodule

// File: rtl/utmr_core.sv
// Module: utmr_core
// Holds the count. A software write wins; otherwise each tick steps the
// count or reloads it at the bound and reports a time-out.
// Assumes: tick is a single-cycle strobe from the prescaler.
module utmr_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             up,
    input  logic             at_limit,
    input  logic [CNT_W-1:0] load_v,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             timeout
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Count register: the write has priority, then reload, then step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_en) begin
            count <= wr_data;
        end else if (tick) begin
            if (at_limit) begin
                count <= load_v;
            end else if (up) begin
                count <= count + ONE;
            end else begin
                count <= count - ONE;
            end
        end
    end

    // A time-out is a tick at the bound that no write overrides.
    always_comb begin
        timeout = tick && at_limit && !wr_en;
    end

    p_wr_prio_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> count == $past(wr_data));

    p_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(count));

    p_step_up_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && up && !at_limit) |=> count == CNT_W'($past(count) + ONE));

    p_step_dn_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && !up && !at_limit) |=> count == CNT_W'($past(count) - ONE));

    p_reload_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> count == $past(load_v));

endmodule

// File: rtl/utmr_flags.sv
// Module: utmr_flags
// Sticky time-out flag and the toggling extension bit.
// Assumes: timeout is a single-cycle strobe.
module utmr_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic timeout,
    input  logic updn_en,
    input  logic clr,
    output logic tf,
    output logic ext
);

    // Time-out flag: setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tf <= 1'b0;
        end else if (timeout) begin
            tf <= 1'b1;
        end else if (clr) begin
            tf <= 1'b0;
        end
    end

    // Extension bit: inverts on each time-out in up/down operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext <= 1'b0;
        end else if (timeout && updn_en) begin
            ext <= ~ext;
        end
    end

    p_tf_sticky_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (tf && !clr) |=> tf);

    p_ext_quiet_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        !updn_en |=> $stable(ext));

endmodule

// File: rtl/updown_reload_timer.sv
// Module: updown_reload_timer
// Top level: the reload and top registers, direction selection, and the
// prescaler, bound decoder, count core and flag instances.
// Assumes: synchronous active-low reset; all write strobes last one cycle.
module updown_reload_timer
    import utmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PS_W-1:0]  psel,
    input  logic             updn_en,
    input  logic             dir,
    input  logic             bound_sel,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] rld_wdata,
    input  logic             top_we,
    input  logic [CNT_W-1:0] top_wdata,
    input  logic             tf_clr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] rld_q,
    output logic [CNT_W-1:0] top_q,
    output logic             tf,
    output logic             ext
);

    logic             tick;
    logic             up;
    logic             at_limit;
    logic [CNT_W-1:0] load_v;
    logic             timeout;
    bound_e           bsel;

    // The direction input only matters when up/down operation is enabled.
    always_comb begin
        up   = !updn_en || dir;
        bsel = bound_e'(bound_sel);
    end

    // Reload (floor) register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= '0;
        end else if (rld_we) begin
            rld_q <= rld_wdata;
        end
    end

    // Top (ceiling) register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else if (top_we) begin
            top_q <= top_wdata;
        end
    end

    utmr_prescale #(.PS_W(PS_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .psel  (psel),
        .tick  (tick)
    );

    utmr_bounds #(.CNT_W(CNT_W)) u_bnd (
        .bsel     (bsel),
        .up       (up),
        .count    (count),
        .floor_v  (rld_q),
        .top_v    (top_q),
        .at_limit (at_limit),
        .load_v   (load_v)
    );

    utmr_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .up       (up),
        .at_limit (at_limit),
        .load_v   (load_v),
        .wr_en    (cnt_we),
        .wr_data  (cnt_wdata),
        .count    (count),
        .timeout  (timeout)
    );

    utmr_flags u_flg (
        .clk     (clk),
        .rst_n   (rst_n),
        .timeout (timeout),
        .updn_en (updn_en),
        .clr     (tf_clr),
        .tf      (tf),
        .ext     (ext)
    );

    // An inverted extension bit always comes with the time-out flag set.
    p_ext_with_tf_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ext) |-> tf);

    // A time-out never happens while the count is being written.
    p_no_timeout_on_write_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |-> !timeout);

endmodule

// File: tb/test_updown_reload_timer.sv
// Scoreboard bench: the driver pushes the expected count and flags for each
// checked cycle; the monitor pops them 1 ns after the clock edge and compares.
module test_updown_reload_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [3:0]  psel = '0;
    logic        updn_en = 1'b0;
    logic        dir = 1'b0;
    logic        bsel = 1'b0;
    logic        cnt_we = 1'b0;
    logic [15:0] cnt_wd = '0;
    logic        rld_we = 1'b0;
    logic [15:0] rld_wd = '0;
    logic        top_we = 1'b0;
    logic [15:0] top_wd = '0;
    logic        tf_clr = 1'b0;
    logic [15:0] count, rld_q, top_q;
    logic        tf, ext;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] c;
        logic        f;
        logic        e;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    updown_reload_timer i_updown_reload_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .psel      (psel),
        .updn_en   (updn_en),
        .dir       (dir),
        .bound_sel (bsel),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wd),
        .rld_we    (rld_we),
        .rld_wdata (rld_wd),
        .top_we    (top_we),
        .top_wdata (top_wd),
        .tf_clr    (tf_clr),
        .count     (count),
        .rld_q     (rld_q),
        .top_q     (top_q),
        .tf        (tf),
        .ext       (ext)
    );

    task automatic direct(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Queue an expectation for the coming edge, then advance to the next falling edge.
    task automatic step(input bit chk, input logic [15:0] c, input logic f,
                        input logic e, input string tag);
        if (chk) q.push_back('{c, f, e, tag});
        @(negedge clk);
        cnt_we = 1'b0;
        rld_we = 1'b0;
        top_we = 1'b0;
        tf_clr = 1'b0;
    endtask

    // Monitor: compare outputs just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                nchk++;
                if (count !== it.c || tf !== it.f || ext !== it.e) begin
                    nfail++;
                    $display("FAIL %s actual cnt=%h tf=%b ext=%b expected cnt=%h tf=%b ext=%b",
                             it.tag, count, tf, ext, it.c, it.f, it.e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        direct("R1 count", count, 16'h0000);
        direct("R1 reload", rld_q, 16'h0000);
        direct("R1 top", top_q, 16'h0000);
        direct("R1 flags", {14'd0, tf, ext}, 16'h0000);
        rst_n = 1'b1;

        rld_we = 1'b1; rld_wd = 16'h0010;
        top_we = 1'b1; top_wd = 16'h0020;
        step(0, 0, 0, 0, "");
        direct("R6 reload reg", rld_q, 16'h0010);
        direct("R7 top reg", top_q, 16'h0020);

        // Up-only, bounds all-ones/floor; dir low is ignored (R3)
        cnt_we = 1'b1; cnt_wd = 16'hFFFD;
        step(1, 16'hFFFD, 0, 0, "R10 load");
        run = 1'b1;
        step(1, 16'hFFFE, 0, 0, "R3 up-only");
        step(1, 16'hFFFF, 0, 0, "R3 up-only");
        step(1, 16'h0010, 1, 0, "R4 wrap to floor");
        step(1, 16'h0011, 1, 0, "R8 ext quiet");
        run = 1'b0; tf_clr = 1'b1;
        step(1, 16'h0011, 0, 0, "R9 clear");

        // Down in all-ones/floor scheme
        updn_en = 1'b1; dir = 1'b0;
        cnt_we = 1'b1; cnt_wd = 16'h0012;
        step(1, 16'h0012, 0, 0, "R10 load");
        run = 1'b1;
        step(1, 16'h0011, 0, 0, "R3 down");
        step(1, 16'h0010, 0, 0, "R3 down");
        step(1, 16'hFFFF, 1, 1, "R5 floor to ones");
        step(1, 16'hFFFE, 1, 1, "R5 continue");
        run = 1'b0; tf_clr = 1'b1;
        step(1, 16'hFFFE, 0, 1, "R9 clear");
        dir = 1'b1; run = 1'b1;
        step(1, 16'hFFFF, 0, 1, "R4 up");
        tf_clr = 1'b1;
        step(1, 16'h0010, 1, 0, "R9 set wins");
        step(1, 16'h0011, 1, 0, "R9 sticky");

        // Top/floor scheme
        run = 1'b0; bsel = 1'b1; tf_clr = 1'b1;
        cnt_we = 1'b1; cnt_wd = 16'h001E;
        step(1, 16'h001E, 0, 0, "R10 load");
        run = 1'b1;
        step(1, 16'h001F, 0, 0, "R6 up");
        step(1, 16'h0020, 0, 0, "R6 up");
        step(1, 16'h0010, 1, 1, "R6 top to floor");
        step(1, 16'h0011, 1, 1, "R6 continue");
        dir = 1'b0;
        step(1, 16'h0010, 1, 1, "R7 down");
        step(1, 16'h0020, 1, 0, "R7 floor to top");

        // R11 down period: 17 steps back to the top value
        tf_clr = 1'b1;
        for (int i = 0; i < 16; i++) step(0, 0, 0, 0, "");
        step(1, 16'h0020, 1, 1, "R11 down period");
        dir = 1'b1;
        step(1, 16'h0010, 1, 0, "R11 reversal at bound");
        tf_clr = 1'b1;
        for (int i = 0; i < 16; i++) step(0, 0, 0, 0, "");
        step(1, 16'h0010, 1, 1, "R11 up period");

        // R2 prescale by 4
        run = 1'b0; bsel = 1'b0; updn_en = 1'b0; psel = 4'd2; tf_clr = 1'b1;
        cnt_we = 1'b1; cnt_wd = 16'h0100;
        step(1, 16'h0100, 0, 1, "R2 load");
        run = 1'b1;
        step(1, 16'h0100, 0, 1, "R2 wait");
        step(1, 16'h0100, 0, 1, "R2 wait");
        step(1, 16'h0100, 0, 1, "R2 wait");
        step(1, 16'h0101, 0, 1, "R2 tick");
        step(1, 16'h0101, 0, 1, "R2 wait");
        step(1, 16'h0101, 0, 1, "R2 wait");
        step(1, 16'h0101, 0, 1, "R2 wait");
        step(1, 16'h0102, 0, 1, "R2 tick");
        run = 1'b0;
        step(1, 16'h0102, 0, 1, "R2 stopped");
        step(1, 16'h0102, 0, 1, "R2 stopped");

        // R10 write in a cycle that would wrap
        psel = 4'd0;
        cnt_we = 1'b1; cnt_wd = 16'hFFFF;
        step(1, 16'hFFFF, 0, 1, "R10 load");
        run = 1'b1; cnt_we = 1'b1; cnt_wd = 16'h1234;
        step(1, 16'h1234, 0, 1, "R10 write beats wrap");
        step(1, 16'h1235, 0, 1, "R10 resumes");
        run = 1'b0;
        step(0, 0, 0, 0, "");
        step(0, 0, 0, 0, "");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule